// File: doc/BRIEF.md
# SPI Pad Ownership and Mode-Fault Controller

This block sits between a serial peripheral interface's shift engine, a general-purpose I/O port and the four physical pads that the interface shares with that port: serial clock, master-out, master-in and slave select. Three control bits decide an operating mode. The bits are the interface enable, the master select and the fault-detect enable. For each pad the mode then decides whether the interface or the port register pair (direction and output data) drives its output enable and output value.

The slave-select pad has the most varied role. When the interface is off, or acts as a master without fault detection, it is a plain port pin. As a slave it is the select input. As a master with fault detection it is an input-only collision detector. When another master pulls it low, a sticky fault flag is raised and the master bit is cleared, so the block drops to slave and releases the clock and master-out pads. A slave with fault detection enabled flags a fault when its select rises while a transfer is in progress. The select level is resynchronised before any fault decision. The raw level of every pad stays readable by software at all times.

Top module: `spi_pad_mux`

## Requirements
- R1: `modeOut` is 0 when the enable bit is 0, whatever the other bits hold; 1 for slave (enable 1, master 0); 2 for master with fault detection off; 3 for master with fault detection on. Control bits load on a clock edge with `cfgWrEn` high.
- R2: In mode 0, `padOe` equals `portDir` and `padOut` equals `portOut` on all four pads (bit 0 clock, bit 1 master-out, bit 2 master-in, bit 3 select).
- R3: In mode 1, the clock, master-out and select pads are inputs (output enable 0). The master-in pad carries `engMisoOut` and is enabled only while the select pad is low.
- R4: In mode 2, the clock and master-out pads are enabled and carry `engSckOut` and `engMosiOut`. The master-in pad is an input. The select pad follows `portDir[3]` and `portOut[3]`.
- R5: In mode 3, the select pad is an input whatever `portDir[3]` holds; the other pads behave as in mode 2.
- R6: `pinLevel` always equals `padIn`, in every mode.
- R7: In mode 3, a low level on the select pad sets `faultFlag` and clears `masterBit` on the third rising clock edge after the pad goes low (two synchronizer stages, then the flag).
- R8: While `faultFlag` is 1, the clock and master-out pads are released, and a configuration write of master = 1 leaves `masterBit` at 0.
- R9: `faultFlag` is sticky. It clears on the edge after `faultClr` is high, and a fault set in the same cycle as a clear takes priority.
- R10: In mode 1 with fault detection on, a high synchronized select while `engBusy` is 1 sets `faultFlag` on the next edge. With fault detection off, it does not.
- R11: `engSckIn` is the clock pad level. `engRxBit` is the master-in pad in modes 2 and 3 and the master-out pad otherwise. `engSlaveSel` is the select pad level in mode 1 and 1 in every other mode.
- R12: After reset, `modeOut` is 0, `masterBit` is 0 and `faultFlag` is 0.
- R13: In mode 2, a low select pad never sets `faultFlag`, and `masterBit` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Load the three control bits |
| cfgEnable | input | 1 | Interface enable bit to load |
| cfgMaster | input | 1 | Master select bit to load |
| cfgFaultEn | input | 1 | Fault-detect enable bit to load |
| faultClr | input | 1 | Write-one-to-clear strobe for the fault flag |
| engBusy | input | 1 | Shift engine has a transfer in progress |
| engSckOut | input | 1 | Serial clock from the engine (master) |
| engMosiOut | input | 1 | Transmit bit from the engine (master) |
| engMisoOut | input | 1 | Transmit bit from the engine (slave) |
| portDir | input | 4 | Port direction register, 1 = output |
| portOut | input | 4 | Port output data register |
| padIn | input | 4 | Pad input levels |
| padOe | output | 4 | Pad output enables |
| padOut | output | 4 | Pad output values |
| pinLevel | output | 4 | Raw pad levels for software reads |
| engSckIn | output | 1 | Clock pad level to the engine |
| engRxBit | output | 1 | Receive bit to the engine |
| engSlaveSel | output | 1 | Select level seen by the engine (low = selected) |
| modeOut | output | 2 | Decoded operating mode |
| masterBit | output | 1 | Current master select bit |
| faultFlag | output | 1 | Sticky mode-fault flag |

## Verification
Each of the eight control-bit settings is combined with every pattern of direction register, output register and pad level, and with all engine output values. The sweep tells apart which pads the interface owns in each mode, which follow the port, and where the receive bit and select are taken from. A separate directed sequence walks the select pad low in each master variant. It checks the exact edge on which the flag appears, that a same-cycle clear loses, and that writes of the master bit are blocked while flagged. It also covers the slave-side fault that depends on the busy input and the fault-detect bit.

// File: rtl/spi_pad_pkg.sv
package spi_pad_pkg;
  localparam int PAD_COUNT = 4;
  localparam int PAD_SCK   = 0;
  localparam int PAD_MOSI  = 1;
  localparam int PAD_MISO  = 2;
  localparam int PAD_SS    = 3;

  typedef enum logic [1:0] {
    MODE_OFF       = 2'd0,
    MODE_SLAVE     = 2'd1,
    MODE_MASTER    = 2'd2,
    MODE_MASTER_FD = 2'd3
  } spiMode_e;

  typedef struct packed {
    spiMode_e mode;
    logic     busRelease;
  } padCtl_t;
endpackage

// File: rtl/spi_pad_ctrl.sv
module spi_pad_ctrl
  import spi_pad_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cfgWrEn,
  input  logic    cfgEnable,
  input  logic    cfgMaster,
  input  logic    cfgFaultEn,
  input  logic    faultClr,
  input  logic    engBusy,
  input  logic    ssPad,
  output padCtl_t ctl,
  output logic    masterBit,
  output logic    faultFlag
);
  localparam int LAST = SYNC_STAGES - 1;

  logic enReg, msReg, feReg;
  logic [SYNC_STAGES-1:0] ssChain;
  logic ssSync;
  logic setFault;
  spiMode_e modeNow;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ssChain <= '1;
        else       ssChain <= ssPad;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ssChain <= '1;
        else       ssChain <= {ssChain[SYNC_STAGES-2:0], ssPad};
      end
    end
  endgenerate

  assign ssSync = ssChain[LAST];

  always_comb begin
    if (!enReg)      modeNow = MODE_OFF;
    else if (!msReg) modeNow = MODE_SLAVE;
    else if (feReg)  modeNow = MODE_MASTER_FD;
    else             modeNow = MODE_MASTER;
  end

  assign setFault = ((modeNow == MODE_MASTER_FD) && !ssSync) ||
                    ((modeNow == MODE_SLAVE) && feReg && engBusy && ssSync);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      msReg     <= 1'b0;
      feReg     <= 1'b0;
      faultFlag <= 1'b0;
    end else begin
      if (cfgWrEn) begin
        enReg <= cfgEnable;
        feReg <= cfgFaultEn;
        msReg <= cfgMaster && !faultFlag;
      end
      if (setFault) msReg <= 1'b0;
      faultFlag <= setFault || (faultFlag && !faultClr);
    end
  end

  assign masterBit      = msReg;
  assign ctl.mode       = modeNow;
  assign ctl.busRelease = faultFlag;

  AST_FLAG_BLOCKS_MASTER: assert property (@(posedge clk) disable iff (!rstN)
    faultFlag |-> !masterBit); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlag && !faultClr) |=> faultFlag); // R9
  AST_NO_FAULT_WITHOUT_FE: assert property (@(posedge clk) disable iff (!rstN)
    (!faultFlag && !feReg) |=> !faultFlag); // R13
  AST_FAULT_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultFlag) |-> (ctl.mode != MODE_MASTER_FD)); // R7
endmodule

// File: rtl/spi_pad_datapath.sv
module spi_pad_datapath
  import spi_pad_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  padCtl_t              ctl,
  input  logic                 engSckOut,
  input  logic                 engMosiOut,
  input  logic                 engMisoOut,
  input  logic [PAD_COUNT-1:0] portDir,
  input  logic [PAD_COUNT-1:0] portOut,
  input  logic [PAD_COUNT-1:0] padIn,
  output logic [PAD_COUNT-1:0] padOe,
  output logic [PAD_COUNT-1:0] padOut,
  output logic [PAD_COUNT-1:0] pinLevel,
  output logic                 engSckIn,
  output logic                 engRxBit,
  output logic                 engSlaveSel
);
  logic [PAD_COUNT-1:0] spiOwn, spiOe, spiVal;

  always_comb begin
    spiOwn = '0;
    spiOe  = '0;
    spiVal = '0;
    unique case (ctl.mode)
      MODE_OFF: ;
      MODE_SLAVE: begin
        spiOwn           = '1;
        spiOe[PAD_MISO]  = !padIn[PAD_SS];
        spiVal[PAD_MISO] = engMisoOut;
      end
      MODE_MASTER, MODE_MASTER_FD: begin
        spiOwn[PAD_SCK]  = 1'b1;
        spiOwn[PAD_MOSI] = 1'b1;
        spiOwn[PAD_MISO] = 1'b1;
        spiOwn[PAD_SS]   = (ctl.mode == MODE_MASTER_FD);
        spiOe[PAD_SCK]   = 1'b1;
        spiOe[PAD_MOSI]  = 1'b1;
        spiVal[PAD_SCK]  = engSckOut;
        spiVal[PAD_MOSI] = engMosiOut;
      end
      default: ;
    endcase
    if (ctl.busRelease) begin
      spiOe[PAD_SCK]  = 1'b0;
      spiOe[PAD_MOSI] = 1'b0;
    end
  end

  generate
    for (genvar i = 0; i < PAD_COUNT; i++) begin : g_pad
      assign padOe[i]  = spiOwn[i] ? spiOe[i]  : portDir[i];
      assign padOut[i] = spiOwn[i] ? spiVal[i] : portOut[i];
    end
  endgenerate

  assign pinLevel    = padIn;
  assign engSckIn    = padIn[PAD_SCK];
  assign engRxBit    = ctl.mode[1] ? padIn[PAD_MISO] : padIn[PAD_MOSI];
  assign engSlaveSel = (ctl.mode == MODE_SLAVE) ? padIn[PAD_SS] : 1'b1;

  AST_OFF_FOLLOWS_PORT: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mode == MODE_OFF) |-> (padOe == portDir && padOut == portOut)); // R2
  AST_SLAVE_INPUTS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mode == MODE_SLAVE) |-> (!padOe[PAD_SCK] && !padOe[PAD_MOSI] && !padOe[PAD_SS])); // R3
  AST_SLAVE_MISO_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mode == MODE_SLAVE && padIn[PAD_SS]) |-> !padOe[PAD_MISO]); // R3
  AST_FD_SS_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mode == MODE_MASTER_FD) |-> !padOe[PAD_SS]); // R5
  AST_RELEASE_BUS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busRelease |-> (!padOe[PAD_SCK] && !padOe[PAD_MOSI])); // R8
endmodule

// File: rtl/spi_pad_mux.sv
module spi_pad_mux
  import spi_pad_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic       cfgEnable,
  input  logic       cfgMaster,
  input  logic       cfgFaultEn,
  input  logic       faultClr,
  input  logic       engBusy,
  input  logic       engSckOut,
  input  logic       engMosiOut,
  input  logic       engMisoOut,
  input  logic [3:0] portDir,
  input  logic [3:0] portOut,
  input  logic [3:0] padIn,
  output logic [3:0] padOe,
  output logic [3:0] padOut,
  output logic [3:0] pinLevel,
  output logic       engSckIn,
  output logic       engRxBit,
  output logic       engSlaveSel,
  output logic [1:0] modeOut,
  output logic       masterBit,
  output logic       faultFlag
);
  padCtl_t ctl;

  spi_pad_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgEnable  (cfgEnable),
    .cfgMaster  (cfgMaster),
    .cfgFaultEn (cfgFaultEn),
    .faultClr   (faultClr),
    .engBusy    (engBusy),
    .ssPad      (padIn[PAD_SS]),
    .ctl        (ctl),
    .masterBit  (masterBit),
    .faultFlag  (faultFlag)
  );

  spi_pad_datapath dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .engSckOut   (engSckOut),
    .engMosiOut  (engMosiOut),
    .engMisoOut  (engMisoOut),
    .portDir     (portDir),
    .portOut     (portOut),
    .padIn       (padIn),
    .padOe       (padOe),
    .padOut      (padOut),
    .pinLevel    (pinLevel),
    .engSckIn    (engSckIn),
    .engRxBit    (engRxBit),
    .engSlaveSel (engSlaveSel)
  );

  assign modeOut = ctl.mode;
endmodule

// File: tb/spi_pad_mux_tb_top.sv
module spi_pad_mux_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 0, cfgEnable = 0, cfgMaster = 0, cfgFaultEn = 0;
  logic faultClr = 0, engBusy = 0;
  logic engSckOut = 0, engMosiOut = 0, engMisoOut = 0;
  logic [3:0] portDir = 0, portOut = 0, padIn = 4'hF;
  logic [3:0] padOe, padOut, pinLevel;
  logic engSckIn, engRxBit, engSlaveSel;
  logic [1:0] modeOut;
  logic masterBit, faultFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_pad_mux dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic en, input logic ms, input logic fe);
    @(negedge clk);
    cfgWrEn = 1; cfgEnable = en; cfgMaster = ms; cfgFaultEn = fe;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic clearFault();
    @(negedge clk); faultClr = 1;
    @(negedge clk); faultClr = 0;
  endtask

  task automatic waitNeg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // expected pad view, packed as {oe,out,pin,sckIn,rx,sel}
  function automatic logic [14:0] model(input int m, input logic [3:0] dir, input logic [3:0] po,
                                        input logic [3:0] pin, input logic [2:0] eng);
    logic [3:0] oe, ov;
    logic rx, sel;
    oe = dir; ov = po; rx = pin[1]; sel = 1'b1;
    if (m == 1) begin
      oe = {1'b0, ~pin[3], 2'b00};
      ov = {1'b0, eng[2], 2'b00};
      sel = pin[3];
    end else if (m >= 2) begin
      oe[0] = 1; ov[0] = eng[0];
      oe[1] = 1; ov[1] = eng[1];
      oe[2] = 0; ov[2] = 0;
      if (m == 3) begin oe[3] = 0; ov[3] = 0; end
      rx = pin[2];
    end
    return {oe, ov, pin, pin[0], rx, sel};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    waitNeg(2);
    rstN = 1;
    waitNeg(1);
    chk(modeOut == 0, "R12 mode", modeOut, 0);
    chk(masterBit == 0, "R12 master", masterBit, 0);
    chk(faultFlag == 0, "R12 flag", faultFlag, 0);

    // exhaustive sweep over control bits and pad/port/engine patterns
    for (int c = 0; c < 8; c++) begin
      int m;
      string tag;
      padIn = 4'hF; engBusy = 0;
      waitNeg(3);
      clearFault();
      cfgWrite(c[0], c[1], c[2]);
      m = (!c[0]) ? 0 : (!c[1]) ? 1 : (c[2] ? 3 : 2);
      chk(modeOut == m[1:0], "R1 mode decode", modeOut, m);
      tag = (m == 0) ? "R2/R6/R11" : (m == 1) ? "R3/R6/R11" : (m == 2) ? "R4/R6/R11" : "R5/R6/R11";
      for (int d = 0; d < 16; d++)
        for (int o = 0; o < 16; o++)
          for (int p = 0; p < 16; p++)
            for (int e = 0; e < 8; e++) begin
              logic [14:0] exp, act;
              if (m == 3 && p < 8) continue;
              portDir = d[3:0]; portOut = o[3:0]; padIn = p[3:0];
              {engMisoOut, engMosiOut, engSckOut} = e[2:0];
              #1;
              exp = model(m, d[3:0], o[3:0], p[3:0], e[2:0]);
              act = {padOe, padOut, pinLevel, engSckIn, engRxBit, engSlaveSel};
              chk(act == exp, tag, act, exp);
            end
      chk(faultFlag == 0, "R13 no fault in sweep", faultFlag, 0);
    end

    // R7: master with detection, select low
    padIn = 4'hF; portDir = 4'hF;
    waitNeg(3);
    clearFault();
    cfgWrite(1, 1, 1);
    chk(modeOut == 3 && masterBit, "R1 master fd", {modeOut, masterBit}, 7);
    padIn[3] = 0;
    waitNeg(2);
    chk(faultFlag == 0, "R7 not before third edge", faultFlag, 0);
    waitNeg(1);
    chk(faultFlag == 1, "R7 flag on third edge", faultFlag, 1);
    chk(masterBit == 0, "R7 master cleared", masterBit, 0);
    chk(padOe[1:0] == 2'b00, "R8 bus released", padOe[1:0], 0);
    cfgWrite(1, 1, 1);
    chk(masterBit == 0, "R8 master write blocked", masterBit, 0);
    waitNeg(4);
    chk(faultFlag == 1, "R9 sticky", faultFlag, 1);
    clearFault();
    chk(faultFlag == 0, "R9 cleared", faultFlag, 0);
    padIn[3] = 1;
    waitNeg(3);
    cfgWrite(1, 1, 1);
    chk(masterBit == 1, "R8 master after clear", masterBit, 1);

    // R9: set wins over clear
    @(negedge clk); padIn[3] = 0; faultClr = 1;
    waitNeg(3);
    chk(faultFlag == 1, "R9 set beats clear", faultFlag, 1);
    waitNeg(1);
    faultClr = 0;
    chk(faultFlag == 0, "R9 clear after set", faultFlag, 0);

    // R13: master without detection ignores select
    padIn[3] = 1; waitNeg(3);
    cfgWrite(1, 1, 0);
    padIn[3] = 0;
    waitNeg(6);
    chk(faultFlag == 0, "R13 no fault", faultFlag, 0);
    chk(masterBit == 1, "R13 master kept", masterBit, 1);

    // R10: slave fault on select high while busy
    padIn[3] = 1; waitNeg(3);
    cfgWrite(1, 0, 1);
    waitNeg(2);
    chk(faultFlag == 0, "R10 idle no fault", faultFlag, 0);
    engBusy = 1;
    waitNeg(1);
    chk(faultFlag == 1, "R10 busy fault", faultFlag, 1);
    engBusy = 0;
    clearFault();
    cfgWrite(1, 0, 0);
    engBusy = 1;
    waitNeg(4);
    chk(faultFlag == 0, "R10 fe off no fault", faultFlag, 0);
    engBusy = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule